// File: doc/BRIEF.md
# Clear-on-read interrupt flag register

This block gathers three single-cycle event pulses (periodic tick, alarm match and update-ended) into a latched status byte. Each event sets its own flag whether or not it is enabled. The flag then stays set until software reads the status byte. Three enable bits taken from the control byte mask the flags. The OR of the masked flags appears as a summary bit in the status byte and drives a registered, active-high interrupt request.

A read strobe from the bus decoder marks the cycle in which the status byte is sampled. At the next clock edge every flag is cleared as a side effect of that read. The one exception is a flag whose event arrives in that same cycle: it stays set so that the event is not lost.

Top module: `evt_flag_reg`

## Requirements
- R1: After reset, the status byte reads 0x00 and `irq` is low.
- R2: An event pulse sets its flag at the next clock edge, whatever the state of its enable. The periodic flag is status bit 6, the alarm flag is bit 5 and the update-ended flag is bit 4.
- R3: A set flag stays set in every cycle in which `rd_stb` is low.
- R4: A cycle with `rd_stb` high clears all three flags at the next clock edge.
- R5: An event that arrives in the same cycle as `rd_stb` leaves its flag set after that edge.
- R6: Status bit 7 is high exactly when some flag is set and its enable bit is also set. Control bit 6 enables the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag.
- R7: `irq` is a register. It holds the value that bit 7 takes after each clock edge, computed with the enables of the cycle before that edge. It therefore rises in the cycle after an enabled event and falls in the cycle after a clearing read.
- R8: Status bits 3 to 0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| ctl_byte | input | 8 | Control byte; bits 6..4 are the enables |
| rd_stb | input | 1 | Status read strobe; clears the flags |
| status | output | 8 | Summary bit, flags and zero-filled low bits |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: a status byte of 8 bits, 3 events with the lowest flag at bit 4, and the summary at bit 7. These values place every flag and the summary at the bit positions stated in the requirements. They also let each enable and flag be exercised alone and in combination. The bench covers the case of an event meeting a clearing read, enables that change while a flag is pending, and the low bits held at zero while the control byte's low bits are driven to one.

// File: rtl/evt_flag_reg.sv
module evt_flag_reg #(
  parameter int STATUS_W = 8,
  parameter int EVT_N    = 3,
  parameter int EVT_LSB  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_periodic,
  input  logic                evt_alarm,
  input  logic                evt_update,
  input  logic [STATUS_W-1:0] ctl_byte,
  input  logic                rd_stb,
  output logic [STATUS_W-1:0] status,
  output logic                irq
);
  localparam int EVT_MSB = EVT_LSB + EVT_N - 1;
  localparam int SUM_BIT = STATUS_W - 1;

  logic [EVT_N-1:0] evt_v;
  logic [EVT_N-1:0] flag_q;
  logic [EVT_N-1:0] flag_d;
  logic [EVT_N-1:0] en_v;

  assign evt_v = {evt_periodic, evt_alarm, evt_update};
  assign en_v  = ctl_byte[EVT_MSB:EVT_LSB];

  for (genvar i = 0; i < EVT_N; i++) begin : g_flag
    assign flag_d[i] = evt_v[i] | (flag_q[i] & ~rd_stb);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flag_d & en_v);
  end

  always_comb begin
    status                  = '0;
    status[EVT_MSB:EVT_LSB] = flag_q;
    status[SUM_BIT]         = |(flag_q & en_v);
  end
endmodule

module evt_flag_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_periodic,
  input logic       evt_alarm,
  input logic       evt_update,
  input logic [7:0] ctl_byte,
  input logic       rd_stb,
  input logic [7:0] status,
  input logic       irq
);
  logic [2:0] ev;
  assign ev = {evt_periodic, evt_alarm, evt_update};

  always_comb begin
    if (!rst_n) assert_reset_clear_R1: assert (status == 8'h00);
  end

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |ev |=> ((status[6:4] & $past(ev)) == $past(ev)));

  assert_flag_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((status[6:4] & $past(status[6:4])) == $past(status[6:4])));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !(|ev)) |=> (status[6:4] == 3'b000));

  assert_read_keeps_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && |ev) |=> (status[6:4] == $past(ev)));

  assert_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == |(status[6:4] & ctl_byte[6:4]));

  assert_irq_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ctl_byte) |-> (irq == status[7]));

  assert_low_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:0] == 4'h0);
endmodule

bind evt_flag_reg evt_flag_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_periodic(evt_periodic), .evt_alarm(evt_alarm),
  .evt_update(evt_update), .ctl_byte(ctl_byte), .rd_stb(rd_stb),
  .status(status), .irq(irq)
);

// File: tb/evt_flag_reg_tb.sv
module evt_flag_reg_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       evt_periodic = 0, evt_alarm = 0, evt_update = 0;
  logic [7:0] ctl_byte = 0;
  logic       rd_stb = 0;
  logic [7:0] status;
  logic       irq;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  evt_flag_reg u_dut (
    .clk(clk), .rst_n(rst_n), .evt_periodic(evt_periodic), .evt_alarm(evt_alarm),
    .evt_update(evt_update), .ctl_byte(ctl_byte), .rd_stb(rd_stb),
    .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    evt_periodic = 0; evt_alarm = 0; evt_update = 0; rd_stb = 0;
  endtask

  task automatic do_read();
    rd_stb = 1; step();
  endtask

  task automatic t_reset();
    chk("R1 reset", {irq, status}, 9'h000);
  endtask

  task automatic t_enabled_periodic();
    ctl_byte = 8'h40; evt_periodic = 1; step();
    chk("R2 periodic flag", {irq, status}, 9'h1C0);
    step(); step();
    chk("R3 hold", {irq, status}, 9'h1C0);
    do_read();
    chk("R4 R7 clear", {irq, status}, 9'h000);
  endtask

  task automatic t_disabled_events();
    ctl_byte = 8'h00; evt_alarm = 1; step();
    chk("R2 alarm disabled", {irq, status}, 9'h020);
    evt_update = 1; step();
    chk("R6 no summary", {irq, status}, 9'h030);
    ctl_byte = 8'h10;
    #1 chk("R6 summary on enable", {1'b0, status}, 9'h0B0);
    step();
    chk("R7 irq after enable", {irq, status}, 9'h1B0);
    do_read();
    chk("R4 clear two", {irq, status}, 9'h000);
  endtask

  task automatic t_read_collision();
    ctl_byte = 8'h20; evt_periodic = 1; step();
    chk("R6 masked periodic", {irq, status}, 9'h040);
    evt_alarm = 1; rd_stb = 1; step();
    chk("R5 keep colliding", {irq, status}, 9'h1A0);
    do_read();
    chk("R4 later clear", {irq, status}, 9'h000);
  endtask

  task automatic t_low_bits();
    ctl_byte = 8'hFF; evt_periodic = 1; evt_alarm = 1; evt_update = 1; step();
    chk("R8 low zero", {irq, status}, 9'h1F0);
    do_read();
    chk("R8 after read", {irq, status}, 9'h000);
    step();
    chk("R3 idle stays clear", {irq, status}, 9'h000);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_enabled_periodic();
    t_disabled_events();
    t_read_collision();
    t_low_bits();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule